// File: doc/BRIEF.md
# Fetch-Group Next-Address Predictor

This block produces the next fetch address for a front end that reads four 32-bit instructions per access. A small set-associative cache holds the exact target of each branch that has been seen taken, together with the slot that branch occupies inside its aligned 16-byte group. A separate table of one-bit direction flags records whether each branch went taken on its most recent execution. The block is looked up combinationally in the first of the two fetch stages.

Within the fetched group, every slot at or after the entry slot is checked. A slot qualifies when its direction flag is set and a cached way with the group's tag records that slot. The lowest qualifying slot supplies the predicted target and slot index. Otherwise the block returns the next sequential group. The resolve stage reports every executed branch through an update port. A taken outcome writes the target into the cache, reusing the branch's own way when it is already present and otherwise replacing the least recently used way of the set. Every outcome writes the direction flag.

Top module: `fetch_target_predictor`

## Requirements
- R1: After reset, no lookup predicts taken, and `next_fetch_addr` equals the fetch address with bits [3:0] cleared, plus 16.
- R2: After a taken update for branch PC p with target t, a lookup anywhere in p's group at or before p's slot predicts taken. It returns `pred_slot` = p[3:2], and `pred_target` and `next_fetch_addr` both equal t.
- R3: When several branches in one group are predicted taken, the one with the lowest slot index supplies the prediction.
- R4: Slots below the entry slot `fetch_addr[3:2]` are never chosen, even when they hold a predicted-taken branch.
- R5: A not-taken update clears that branch's direction flag, so the branch stops predicting taken until a later taken update. A not-taken update never allocates or replaces a cache way.
- R6: A taken update whose branch (same set, tag and slot) is already cached overwrites that way's target and does not allocate a second way.
- R7: The set index is address bit 4 and the tag is bits [31:5]. A taken update that misses replaces the least recently used of the set's 4 ways. Entries of the other set are unaffected.
- R8: A lookup with `fetch_valid` high that predicts taken makes the supplying way the most recent in its set. A lookup with `fetch_valid` low changes no replacement order.
- R9: The direction table holds 64 flags indexed by PC bits [7:2], kept apart from the target cache. Every update writes the actual outcome into the flag at its index, so branches sharing that index share the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Lookup is a real fetch and may refresh replacement order |
| fetch_addr | input | 32 | Fetch address; bits [3:2] give the entry slot |
| pred_taken | output | 1 | A predicted-taken branch was found in the group |
| pred_slot | output | 2 | Slot of the chosen branch within the group |
| pred_target | output | 32 | Cached target of the chosen branch |
| next_fetch_addr | output | 32 | Predicted target, or the next sequential group |
| upd_valid | input | 1 | Resolved branch report |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction |
| upd_target | input | 32 | Actual target |

## Verification
On every cycle, the assertions check three things: the replacement ranks of each set remain a permutation of the way numbers, no two valid ways ever describe the same branch, and a freshly written way becomes most recent. They also check that each update leaves its outcome in the direction flag it addresses and that not-taken updates leave the tag array untouched. Only the bench's scenarios show what these invariants cannot. Those are the choice of the first taken slot after the entry slot, the eviction of the oldest way after refreshes and ignored lookups, target overwrite on a hit, and flag sharing between aliasing branches.

// File: rtl/ftp_pkg.sv
package ftp_pkg;

   localparam int unsigned FTP_INSN_BYTES = 4;

   // Source of the replacement-order touch in a given cycle
   typedef enum logic [1:0] {
      ACT_IDLE  = 2'd0,
      ACT_FETCH = 2'd1,
      ACT_WRITE = 2'd2
   } ftp_act_e;

endpackage

// File: rtl/ftp_dir_table.sv
module ftp_dir_table #(
   parameter int PC_W        = 32,
   parameter int DIR_ENTRIES = 64,
   parameter int SLOTS       = 4,
   parameter int IDX_W       = $clog2(DIR_ENTRIES),
   parameter int SLOT_W      = $clog2(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PC_W-1:0]  group_addr,
   output logic [SLOTS-1:0] dir_bits,
   input  logic             upd_valid,
   input  logic [PC_W-1:0]  upd_pc,
   input  logic             upd_taken
);
   localparam int LSB = $clog2(ftp_pkg::FTP_INSN_BYTES);

   if (IDX_W < SLOT_W) begin : g_bad_idx
      $error("direction table must cover a whole group");
   end

   logic [DIR_ENTRIES-1:0] dir_q;
   logic [IDX_W-1:0]       up_idx;

   assign up_idx = upd_pc[LSB +: IDX_W];

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [IDX_W-1:0] rd_idx;
      assign rd_idx      = group_addr[LSB +: IDX_W] | IDX_W'(s);
      assign dir_bits[s] = dir_q[rd_idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) dir_q <= '0;
      else if (upd_valid) dir_q[up_idx] <= upd_taken;
   end

   AST_DIR_FOLLOWS_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |=> dir_q[$past(up_idx)] == $past(upd_taken)); // R9

endmodule

// File: rtl/ftp_tag_store.sv
module ftp_tag_store #(
   parameter int PC_W   = 32,
   parameter int WAYS   = 4,
   parameter int SETS   = 2,
   parameter int SLOTS  = 4,
   parameter int WAY_W  = $clog2(WAYS),
   parameter int SET_W  = $clog2(SETS),
   parameter int SLOT_W = $clog2(SLOTS),
   parameter int TAG_W  = PC_W - SLOT_W - 2 - SET_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [SET_W-1:0]             lk_set,
   input  logic [TAG_W-1:0]             lk_tag,
   output logic [WAYS-1:0]              lk_hit,
   output logic [WAYS-1:0][SLOT_W-1:0]  lk_slot,
   output logic [WAYS-1:0][PC_W-1:0]    lk_target,
   input  logic                         lk_touch,
   input  logic [WAY_W-1:0]             lk_touch_way,
   input  logic                         up_valid,
   input  logic                         up_taken,
   input  logic [SET_W-1:0]             up_set,
   input  logic [TAG_W-1:0]             up_tag,
   input  logic [SLOT_W-1:0]            up_slot,
   input  logic [PC_W-1:0]              up_target
);
   import ftp_pkg::*;

   logic [SETS-1:0][WAYS-1:0]             valid_q;
   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
   logic [SETS-1:0][WAYS-1:0][SLOT_W-1:0] slot_q;
   logic [SETS-1:0][WAYS-1:0][PC_W-1:0]   tgt_q;
   logic [SETS-1:0][WAYS-1:0][WAY_W-1:0]  age_q;

   logic [WAYS-1:0]  up_hit_vec;
   logic             up_hit;
   logic [WAY_W-1:0] up_hit_way, victim_way, wr_way, tch_way;
   logic [SET_W-1:0] tch_set;
   logic             wr_en;
   ftp_act_e         act;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign lk_hit[w]     = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
      assign lk_slot[w]    = slot_q[lk_set][w];
      assign lk_target[w]  = tgt_q[lk_set][w];
      assign up_hit_vec[w] = valid_q[up_set][w] && (tag_q[up_set][w] == up_tag)
                             && (slot_q[up_set][w] == up_slot);
   end

   assign up_hit = |up_hit_vec;
   assign wr_en  = up_valid && up_taken;

   always_comb begin
      up_hit_way = '0;
      victim_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (up_hit_vec[w]) up_hit_way = WAY_W'(w);
         if (age_q[up_set][w] == WAY_W'(WAYS-1)) victim_way = WAY_W'(w);
      end
      wr_way = up_hit ? up_hit_way : victim_way;
      // A write owns the replacement update; a fetch refresh yields to it
      if (wr_en)         act = ACT_WRITE;
      else if (lk_touch) act = ACT_FETCH;
      else               act = ACT_IDLE;
      tch_set = (act == ACT_WRITE) ? up_set : lk_set;
      tch_way = (act == ACT_WRITE) ? wr_way : lk_touch_way;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         tag_q   <= '0;
         slot_q  <= '0;
         tgt_q   <= '0;
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               age_q[s][w] <= WAY_W'(w);
      end else begin
         if (wr_en) begin
            valid_q[up_set][wr_way] <= 1'b1;
            tag_q[up_set][wr_way]   <= up_tag;
            slot_q[up_set][wr_way]  <= up_slot;
            tgt_q[up_set][wr_way]   <= up_target;
         end
         if (act != ACT_IDLE) begin
            for (int w = 0; w < WAYS; w++) begin
               if (WAY_W'(w) == tch_way)
                  age_q[tch_set][w] <= '0;
               else if (age_q[tch_set][w] < age_q[tch_set][tch_way])
                  age_q[tch_set][w] <= age_q[tch_set][w] + 1'b1;
            end
         end
      end
   end

   for (genvar s = 0; s < SETS; s++) begin : g_rank_chk
      logic [WAYS-1:0] rank_seen;
      always_comb begin
         rank_seen = '0;
         for (int w = 0; w < WAYS; w++) rank_seen[age_q[s][w]] = 1'b1;
      end
      AST_RANKS_PERMUTE: assert property (@(posedge clk) disable iff (!rst_n)
         rank_seen == {WAYS{1'b1}}); // R7
   end

   AST_NO_DUP_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid |-> $countones(up_hit_vec) <= 1); // R6

   AST_WRITE_BECOMES_MRU: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> age_q[$past(up_set)][$past(wr_way)] == '0); // R7

   AST_NOT_TAKEN_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !up_taken) |=> ($stable(valid_q) && $stable(tag_q))); // R5

endmodule

// File: rtl/ftp_first_taken.sv
module ftp_first_taken #(
   parameter int PC_W   = 32,
   parameter int WAYS   = 4,
   parameter int SLOTS  = 4,
   parameter int WAY_W  = $clog2(WAYS),
   parameter int SLOT_W = $clog2(SLOTS)
) (
   input  logic [SLOT_W-1:0]            start_slot,
   input  logic [SLOTS-1:0]             dir_bits,
   input  logic [WAYS-1:0]              way_hit,
   input  logic [WAYS-1:0][SLOT_W-1:0]  way_slot,
   input  logic [WAYS-1:0][PC_W-1:0]    way_target,
   output logic                         taken,
   output logic [SLOT_W-1:0]            slot,
   output logic [PC_W-1:0]              target,
   output logic [WAY_W-1:0]             way
);
   // Scan from the top slot down so that the lowest eligible slot is kept last
   always_comb begin
      taken  = 1'b0;
      slot   = '0;
      target = '0;
      way    = '0;
      for (int s = SLOTS-1; s >= 0; s--) begin
         for (int w = 0; w < WAYS; w++) begin
            if (dir_bits[s] && (SLOT_W'(s) >= start_slot) && way_hit[w]
                && (way_slot[w] == SLOT_W'(s))) begin
               taken  = 1'b1;
               slot   = SLOT_W'(s);
               target = way_target[w];
               way    = WAY_W'(w);
            end
         end
      end
   end

endmodule

// File: rtl/fetch_target_predictor.sv
module fetch_target_predictor #(
   parameter int PC_W        = 32,
   parameter int WAYS        = 4,
   parameter int ENTRIES     = 8,
   parameter int SLOTS       = 4,
   parameter int DIR_ENTRIES = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fetch_valid,
   input  logic [PC_W-1:0]          fetch_addr,
   output logic                     pred_taken,
   output logic [$clog2(SLOTS)-1:0] pred_slot,
   output logic [PC_W-1:0]          pred_target,
   output logic [PC_W-1:0]          next_fetch_addr,
   input  logic                     upd_valid,
   input  logic [PC_W-1:0]          upd_pc,
   input  logic                     upd_taken,
   input  logic [PC_W-1:0]          upd_target
);
   localparam int SETS        = ENTRIES / WAYS;
   localparam int WAY_W       = $clog2(WAYS);
   localparam int SET_W       = $clog2(SETS);
   localparam int SLOT_W      = $clog2(SLOTS);
   localparam int LSB         = $clog2(ftp_pkg::FTP_INSN_BYTES);
   localparam int OFF_W       = SLOT_W + LSB;
   localparam int TAG_W       = PC_W - OFF_W - SET_W;
   localparam int GROUP_BYTES = SLOTS * ftp_pkg::FTP_INSN_BYTES;

   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (SETS < 2 || SETS * WAYS != ENTRIES || (1 << SET_W) != SETS) begin : g_bad_sets
      $error("ENTRIES / WAYS must be a power of two of at least 2");
   end
   if (SLOTS < 2 || (1 << SLOT_W) != SLOTS) begin : g_bad_slots
      $error("SLOTS must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for a tag");
   end

   logic [PC_W-1:0]             group_addr;
   logic [SLOTS-1:0]            dir_bits;
   logic [WAYS-1:0]             way_hit;
   logic [WAYS-1:0][SLOT_W-1:0] way_slot;
   logic [WAYS-1:0][PC_W-1:0]   way_target;
   logic [WAY_W-1:0]            sel_way;

   assign group_addr = {fetch_addr[PC_W-1:OFF_W], {OFF_W{1'b0}}};

   ftp_dir_table #(
      .PC_W(PC_W), .DIR_ENTRIES(DIR_ENTRIES), .SLOTS(SLOTS)
   ) i_dir (
      .clk(clk), .rst_n(rst_n),
      .group_addr(group_addr), .dir_bits(dir_bits),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
   );

   ftp_tag_store #(
      .PC_W(PC_W), .WAYS(WAYS), .SETS(SETS), .SLOTS(SLOTS)
   ) i_tags (
      .clk(clk), .rst_n(rst_n),
      .lk_set(fetch_addr[OFF_W +: SET_W]),
      .lk_tag(fetch_addr[PC_W-1 -: TAG_W]),
      .lk_hit(way_hit), .lk_slot(way_slot), .lk_target(way_target),
      .lk_touch(fetch_valid && pred_taken), .lk_touch_way(sel_way),
      .up_valid(upd_valid), .up_taken(upd_taken),
      .up_set(upd_pc[OFF_W +: SET_W]),
      .up_tag(upd_pc[PC_W-1 -: TAG_W]),
      .up_slot(upd_pc[LSB +: SLOT_W]),
      .up_target(upd_target)
   );

   ftp_first_taken #(
      .PC_W(PC_W), .WAYS(WAYS), .SLOTS(SLOTS)
   ) i_scan (
      .start_slot(fetch_addr[LSB +: SLOT_W]),
      .dir_bits(dir_bits), .way_hit(way_hit),
      .way_slot(way_slot), .way_target(way_target),
      .taken(pred_taken), .slot(pred_slot),
      .target(pred_target), .way(sel_way)
   );

   assign next_fetch_addr = pred_taken ? pred_target : group_addr + PC_W'(GROUP_BYTES);

endmodule

// File: tb/test_fetch_target_predictor.sv
module test_fetch_target_predictor;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_valid = 1'b0;
   logic [31:0] fetch_addr = '0;
   logic        pred_taken;
   logic [1:0]  pred_slot;
   logic [31:0] pred_target;
   logic [31:0] next_fetch_addr;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic        upd_taken = 1'b0;
   logic [31:0] upd_target = '0;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   fetch_target_predictor i_fetch_target_predictor (
      .clk(clk), .rst_n(rst_n),
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
      .pred_taken(pred_taken), .pred_slot(pred_slot),
      .pred_target(pred_target), .next_fetch_addr(next_fetch_addr),
      .upd_valid(upd_valid), .upd_pc(upd_pc),
      .upd_taken(upd_taken), .upd_target(upd_target)
   );

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   task automatic upd(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
      @(negedge clk);
      upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tgt;
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   // Observational lookup: fetch_valid low so replacement order is untouched
   task automatic look(input logic [31:0] addr, input logic exp_tk, input logic [1:0] exp_slot,
                       input logic [31:0] exp_next, input string req);
      @(negedge clk);
      fetch_valid = 1'b0; fetch_addr = addr;
      #2;
      checks++;
      if (pred_taken !== exp_tk || next_fetch_addr !== exp_next ||
          (exp_tk && pred_slot !== exp_slot)) begin
         failures++;
         $display("FAIL %s addr=%h: taken=%b slot=%0d next=%h expected taken=%b slot=%0d next=%h",
                  req, addr, pred_taken, pred_slot, next_fetch_addr, exp_tk, exp_slot, exp_next);
      end
   endtask

   task automatic fetch_touch(input logic [31:0] addr);
      @(negedge clk);
      fetch_valid = 1'b1; fetch_addr = addr;
      @(negedge clk);
      fetch_valid = 1'b0;
   endtask

   task automatic t_reset();
      look(32'h1000, 1'b0, 2'd0, 32'h1010, "R1");
      look(32'h100C, 1'b0, 2'd0, 32'h1010, "R1");
   endtask

   task automatic t_alloc();
      upd(32'h104, 1'b1, 32'h2000);
      look(32'h100, 1'b1, 2'd1, 32'h2000, "R2");
      look(32'h110, 1'b0, 2'd0, 32'h120, "R7");
   endtask

   task automatic t_first_and_start();
      upd(32'h10C, 1'b1, 32'h3000);
      look(32'h100, 1'b1, 2'd1, 32'h2000, "R3");
      look(32'h104, 1'b1, 2'd1, 32'h2000, "R4");
      look(32'h108, 1'b1, 2'd3, 32'h3000, "R4");
   endtask

   task automatic t_last_time();
      upd(32'h104, 1'b0, 32'h0);
      look(32'h100, 1'b1, 2'd3, 32'h3000, "R5");
      upd(32'h10C, 1'b0, 32'h0);
      look(32'h100, 1'b0, 2'd0, 32'h110, "R5");
      upd(32'h104, 1'b1, 32'h2000);
      look(32'h100, 1'b1, 2'd1, 32'h2000, "R5");
   endtask

   task automatic t_overwrite();
      upd(32'h104, 1'b1, 32'h5000);
      look(32'h100, 1'b1, 2'd1, 32'h5000, "R6");
   endtask

   task automatic t_alias();
      // 0x204 and 0x104 share direction index 1 (PC bits [7:2])
      upd(32'h204, 1'b0, 32'h0);
      look(32'h100, 1'b0, 2'd0, 32'h110, "R9");
      upd(32'h104, 1'b1, 32'h5000);
      look(32'h100, 1'b1, 2'd1, 32'h5000, "R9");
   endtask

   task automatic t_lru();
      for (int k = 0; k < 5; k++)
         upd(32'h10 + 32'(k) * 32'h20, 1'b1, 32'h4000 + 32'(k) * 32'h100);
      look(32'h010, 1'b0, 2'd0, 32'h020, "R7");
      look(32'h030, 1'b1, 2'd0, 32'h4100, "R7");
      look(32'h090, 1'b1, 2'd0, 32'h4400, "R7");
      fetch_touch(32'h030);
      upd(32'h0B0, 1'b1, 32'h4500);
      look(32'h050, 1'b0, 2'd0, 32'h060, "R8");
      look(32'h030, 1'b1, 2'd0, 32'h4100, "R8");
      look(32'h070, 1'b1, 2'd0, 32'h4300, "R8");
      upd(32'h0D0, 1'b1, 32'h4600);
      look(32'h070, 1'b0, 2'd0, 32'h080, "R8");
      look(32'h090, 1'b1, 2'd0, 32'h4400, "R8");
      upd(32'h0F0, 1'b0, 32'h7777);
      upd(32'h0F0, 1'b0, 32'h7777);
      look(32'h090, 1'b1, 2'd0, 32'h4400, "R5");
      look(32'h0F0, 1'b0, 2'd0, 32'h100, "R5");
      look(32'h100, 1'b1, 2'd1, 32'h5000, "R7");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      report();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_alloc();
      t_first_and_start();
      t_last_time();
      t_overwrite();
      t_alias();
      t_lru();
      repeat (2) @(negedge clk);
      report();
      $finish;
   end

endmodule